// File: doc/BRIEF.md
# DRAM Auto-Refresh Scheduler

This block keeps a four-bank synchronous DRAM refreshed. A free-running interval timer produces one refresh credit for every refresh slot: the configured cycle count in the normal temperature range, or a quarter of it when the extended (hot) range is selected. The faster rate exists because the hot range must fit the full set of 8192 row refreshes into a 16 ms window instead of 64 ms. Credits accumulate in a pending counter that holds at most eight.

When credit is pending, the scheduler asks the command arbiter for a slot. If any bank still has a row open, it first asks for a precharge-all. Once every bank is idle, it asks for the refresh itself. A one-cycle grant from the arbiter turns the active request into a registered command strobe on the next cycle, already encoded as chip-select, row-strobe, column-strobe and write-enable levels. After a refresh, a hold output stays high for the programmed refresh-cycle time so the arbiter issues nothing else. A full pending counter raises an urgent flag, which the arbiter uses to pre-empt normal traffic.

Top module: `refresh_sched`

## Requirements
- R1: With the extended mode off, the pending count rises by one every `cfg_ref_cycles` clock edges after reset is released, so after n edges it equals n / `cfg_ref_cycles` (integer division) until it saturates.
- R2: With `ext_temp` high, the slot length is `cfg_ref_cycles` shifted right by two, so credits arrive four times as often.
- R3: The pending count never exceeds 8. A credit that falls due while the count is 8 is dropped.
- R4: `ref_urgent` is high exactly when the pending count is 8.
- R5: `ref_req` is high only when credit is pending, all four `bank_open` bits are 0, the hold is low, and no strobe is being driven in the same cycle.
- R6: `pall_req` is high when credit is pending and at least one `bank_open` bit is 1, under the same hold and strobe masking. It is never high together with `ref_req`.
- R7: A grant sampled with `ref_req` high makes `cmd_valid` high for one cycle on the next cycle, with `cmd_code` = {cs_n,ras_n,cas_n,we_n} = 4'b0001. The pending count drops by one in that same cycle.
- R8: A grant sampled with `pall_req` high makes the next cycle a strobe with `cmd_code` = 4'b0010 and `cmd_a10` = 1. The pending count is unchanged.
- R9: `cmd_hold` is high for exactly `cfg_trfc` cycles, beginning with the cycle of the refresh strobe. While it is high, no request is raised and a grant produces no strobe.
- R10: A grant sampled while neither request is high produces no strobe and leaves the pending count unchanged.
- R11: When a credit falls due on the same edge that a refresh is granted, the pending count is unchanged.
- R12: During reset the pending count is 0, all requests and strobes are low, the hold is low, and `cmd_code` reads 4'b0111 (no operation).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ref_cycles | input | CNT_W | Clock cycles per refresh slot in the normal range |
| ext_temp | input | 1 | Selects the quartered slot of the extended range |
| cfg_trfc | input | TRFC_W | Refresh-cycle hold length in cycles (at least 1) |
| bank_open | input | NBANK | One bit per bank, high while a row is active |
| grant | input | 1 | Arbiter accepts the currently raised request |
| ref_req | output | 1 | Refresh wanted, all banks idle |
| pall_req | output | 1 | Precharge-all wanted before a refresh |
| ref_urgent | output | 1 | Pending count at its limit, pre-empt traffic |
| cmd_valid | output | 1 | Command strobe for this cycle |
| cmd_code | output | 4 | {cs_n, ras_n, cas_n, we_n} of the strobe |
| cmd_a10 | output | 1 | Address bit 10 of the strobe (all-banks flag) |
| cmd_hold | output | 1 | Arbiter must issue nothing this cycle |
| pend_cnt | output | PEND_W | Current pending refresh count |

## Verification
A timer that is off by one edge shows up on `pend_cnt` within one refresh slot after reset, and the bench compares that count on every cycle of a sweep over several slot lengths in both temperature modes. A pending counter that wraps instead of saturating shows up one slot after the count reaches 8, as a falling `ref_urgent`. An error in the hold length or in the issue bookkeeping shows up on `cmd_hold`, `cmd_valid` or `pend_cnt` within one cycle of the grant that triggers it.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_NOP  = 4'b0111,
      CMD_REF  = 4'b0001,
      CMD_PALL = 4'b0010
   } dram_cmd_e;
   localparam int unsigned NORM_WINDOW_MS = 64;
   localparam int unsigned EXT_WINDOW_MS  = 16;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
   parameter int unsigned CNT_W      = 16,
   parameter bit          EXT_ENABLE = 1'b1,
   parameter int unsigned EXT_SHIFT  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cfg_cycles,
   input  logic             ext_mode,
   output logic             tick
);
   logic [CNT_W-1:0] iv_raw, iv, tmr;

   generate
      if (EXT_ENABLE) begin : g_ext
         assign iv_raw = ext_mode ? (cfg_cycles >> EXT_SHIFT) : cfg_cycles;
      end else begin : g_norm
         assign iv_raw = cfg_cycles;
      end
   endgenerate

   assign iv   = (iv_raw == '0) ? CNT_W'(1) : iv_raw;
   assign tick = (tmr >= iv - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)    tmr <= '0;
      else if (tick) tmr <= '0;
      else           tmr <= tmr + CNT_W'(1);
   end

   // R1: with a steady slot longer than one cycle, credits never come back to back
   p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && iv > CNT_W'(1)) |=> (!tick || iv != $past(iv)));
endmodule

// File: rtl/ref_pending_ctr.sv
module ref_pending_ctr #(
   parameter int unsigned PEND_MAX = 8,
   localparam int unsigned PEND_W  = $clog2(PEND_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              dec,
   output logic [PEND_W-1:0] pend,
   output logic              urgent
);
   localparam logic [PEND_W-1:0] LIMIT = PEND_W'(PEND_MAX);

   assign urgent = (pend == LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else begin
         unique case ({inc && !urgent, dec})
            2'b10:   pend <= pend + PEND_W'(1);
            2'b01:   pend <= pend - PEND_W'(1);
            2'b11:   pend <= urgent ? pend - PEND_W'(1) : pend;
            default: pend <= pend;
         endcase
      end
   end

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n) pend <= LIMIT);
   p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n) dec |-> pend != '0);
   p_issue_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc) |=> pend == $past(pend) - PEND_W'(1));
   p_tick_and_issue_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && inc && !urgent) |=> pend == $past(pend));
   p_urgent_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(urgent) |-> $past(inc));
endmodule

// File: rtl/ref_trfc_guard.sv
module ref_trfc_guard #(
   parameter int unsigned TRFC_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TRFC_W-1:0] trfc,
   output logic              busy
);
   logic [TRFC_W-1:0] cnt;

   assign busy = (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= trfc;
      else if (busy) cnt <= cnt - TRFC_W'(1);
   end

   p_load_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (load && trfc != '0) |=> busy);
   p_countdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load) |=> cnt == $past(cnt) - TRFC_W'(1));
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
   import refresh_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned TRFC_W   = 6,
   parameter int unsigned PEND_MAX = 8,
   parameter int unsigned NBANK    = 4,
   parameter bit          EXT_ENABLE = 1'b1,
   localparam int unsigned PEND_W  = $clog2(PEND_MAX + 1),
   localparam int unsigned EXT_SHIFT = $clog2(NORM_WINDOW_MS / EXT_WINDOW_MS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cfg_ref_cycles,
   input  logic              ext_temp,
   input  logic [TRFC_W-1:0] cfg_trfc,
   input  logic [NBANK-1:0]  bank_open,
   input  logic              grant,
   output logic              ref_req,
   output logic              pall_req,
   output logic              ref_urgent,
   output logic              cmd_valid,
   output logic [3:0]        cmd_code,
   output logic              cmd_a10,
   output logic              cmd_hold,
   output logic [PEND_W-1:0] pend_cnt
);
   generate
      if (CNT_W < 4)      begin : g_bad_cnt  $error("CNT_W too small");     end
      if (TRFC_W < 1)     begin : g_bad_trfc $error("TRFC_W must be >= 1"); end
      if (PEND_MAX < 1)   begin : g_bad_pend $error("PEND_MAX must be >= 1"); end
      if (NBANK < 1)      begin : g_bad_bank $error("NBANK must be >= 1");  end
   endgenerate

   logic tick, busy, have, issue_ref, issue_pall;

   ref_interval_timer #(.CNT_W(CNT_W), .EXT_ENABLE(EXT_ENABLE), .EXT_SHIFT(EXT_SHIFT)) u_timer (
      .clk(clk), .rst_n(rst_n), .cfg_cycles(cfg_ref_cycles), .ext_mode(ext_temp), .tick(tick));

   ref_pending_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
      .clk(clk), .rst_n(rst_n), .inc(tick), .dec(issue_ref), .pend(pend_cnt), .urgent(ref_urgent));

   ref_trfc_guard #(.TRFC_W(TRFC_W)) u_guard (
      .clk(clk), .rst_n(rst_n), .load(issue_ref), .trfc(cfg_trfc), .busy(busy));

   assign have       = (pend_cnt != '0) && !busy && !cmd_valid;
   assign ref_req    = have && (bank_open == '0);
   assign pall_req   = have && (bank_open != '0);
   assign issue_ref  = grant && ref_req;
   assign issue_pall = grant && pall_req;
   assign cmd_hold   = busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_code  <= CMD_NOP;
         cmd_a10   <= 1'b0;
      end else begin
         cmd_valid <= issue_ref || issue_pall;
         cmd_code  <= issue_ref ? CMD_REF : (issue_pall ? CMD_PALL : CMD_NOP);
         cmd_a10   <= issue_pall;
      end
   end

   p_req_excl_r6: assert property (@(posedge clk) disable iff (!rst_n) !(ref_req && pall_req));
   p_ref_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == CMD_REF) |-> $past(bank_open == '0));
   p_hold_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_hold |-> (!ref_req && !pall_req));
   p_pall_a10_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == CMD_PALL) |-> cmd_a10);
   p_strobe_needs_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(grant));
endmodule

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
   localparam int PEND_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [15:0] cfg_ref_cycles = 16'd60;
   logic ext_temp = 1'b0;
   logic [5:0] cfg_trfc = 6'd6;
   logic [3:0] bank_open = 4'b0;
   logic grant = 1'b0;
   logic ref_req, pall_req, ref_urgent, cmd_valid, cmd_a10, cmd_hold;
   logic [3:0] cmd_code;
   logic [PEND_W-1:0] pend_cnt;

   int compared = 0, mismatched = 0, e = 0;

   always #2.5 clk = ~clk;

   refresh_sched u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_ref_cycles(cfg_ref_cycles), .ext_temp(ext_temp),
      .cfg_trfc(cfg_trfc), .bank_open(bank_open), .grant(grant), .ref_req(ref_req),
      .pall_req(pall_req), .ref_urgent(ref_urgent), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code), .cmd_a10(cmd_a10), .cmd_hold(cmd_hold), .pend_cnt(pend_cnt));

   task automatic chk(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s at edge %0d: actual %0d expected %0d", req, e, act, exp);
      end
   endtask

   task automatic adv();
      @(negedge clk);
      e++;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      grant = 1'b0;
      bank_open = '0;
      @(negedge clk);
      @(negedge clk);
      chk("R12 pend", pend_cnt, 0);
      chk("R12 ref_req", ref_req, 0);
      chk("R12 pall_req", pall_req, 0);
      chk("R12 cmd_valid", cmd_valid, 0);
      chk("R12 cmd_hold", cmd_hold, 0);
      chk("R12 cmd_code", cmd_code, 4'b0111);
      rst_n = 1'b1;
      e = 0;
   endtask

   task automatic sweep(input int cfg, input bit ext, input string tag);
      int iv;
      cfg_ref_cycles = 16'(cfg);
      ext_temp = ext;
      iv = ext ? cfg / 4 : cfg;
      do_reset();
      for (int n = 1; n <= 10 * iv + 2; n++) begin
         int exp;
         adv();
         exp = n / iv;
         if (exp > 8) exp = 8;
         chk({tag, " R3 pend"}, pend_cnt, exp);
         chk("R5 ref_req", ref_req, exp > 0);
         chk("R4 urgent", ref_urgent, exp == 8);
      end
   endtask

   initial begin
      // R1: normal-range slot lengths
      sweep(4, 1'b0, "R1");
      sweep(5, 1'b0, "R1");
      sweep(7, 1'b0, "R1");
      // R2: extended range quarters the slot
      sweep(16, 1'b1, "R2");
      sweep(20, 1'b1, "R2");
      sweep(28, 1'b1, "R2");
      sweep(12, 1'b1, "R2");

      cfg_ref_cycles = 16'd60;
      ext_temp = 1'b0;
      cfg_trfc = 6'd6;
      do_reset();
      // R10: grant with nothing pending
      grant = 1'b1;
      adv();
      grant = 1'b0;
      chk("R10 no strobe", cmd_valid, 0);
      chk("R10 pend", pend_cnt, 0);
      while (e < 180) adv();
      chk("R1 pend at 180", pend_cnt, 3);
      // R7: refresh grant
      grant = 1'b1;
      adv();
      grant = 1'b0;
      chk("R7 strobe", cmd_valid, 1);
      chk("R7 code", cmd_code, 4'b0001);
      chk("R7 pend", pend_cnt, 2);
      chk("R9 hold", cmd_hold, 1);
      chk("R9 ref_req masked", ref_req, 0);
      grant = 1'b1;
      for (int i = 2; i <= 6; i++) begin
         adv();
         chk("R9 hold", cmd_hold, 1);
         chk("R9 grant ignored", cmd_valid, 0);
         chk("R9 pend", pend_cnt, 2);
      end
      grant = 1'b0;
      adv();
      chk("R9 hold end", cmd_hold, 0);
      chk("R5 ref_req back", ref_req, 1);
      // R6/R8: precharge-all path
      bank_open = 4'b0100;
      #1;
      chk("R6 pall_req", pall_req, 1);
      chk("R5 ref_req off", ref_req, 0);
      grant = 1'b1;
      adv();
      grant = 1'b0;
      chk("R8 strobe", cmd_valid, 1);
      chk("R8 code", cmd_code, 4'b0010);
      chk("R8 a10", cmd_a10, 1);
      chk("R8 pend", pend_cnt, 2);
      chk("R6 masked in strobe", pall_req, 0);
      chk("R8 no hold", cmd_hold, 0);
      bank_open = 4'b0;
      adv();
      chk("R5 ref_req", ref_req, 1);
      chk("R10 no strobe", cmd_valid, 0);
      // R11: grant on the credit edge
      while (e < 239) adv();
      grant = 1'b1;
      adv();
      grant = 1'b0;
      chk("R11 strobe", cmd_code, 4'b0001);
      chk("R11 pend", pend_cnt, 2);
      // R3/R4: saturate then drain
      while (e < 600) adv();
      chk("R3 pend at limit", pend_cnt, 8);
      chk("R4 urgent", ref_urgent, 1);
      while (e < 660) adv();
      chk("R3 dropped credit", pend_cnt, 8);
      grant = 1'b1;
      adv();
      grant = 1'b0;
      chk("R7 urgent refresh", cmd_code, 4'b0001);
      chk("R7 pend", pend_cnt, 7);
      chk("R4 urgent cleared", ref_urgent, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule